// File: doc/BRIEF.md
# Emulated Auto-Negotiation Register Controller

This block is the management register set of a virtual Ethernet PHY that has no cable and no link partner. Software reaches five clause-22 style registers through a flat parallel port: an address, a write strobe with write data, a read strobe, and read data that follows the address combinationally. The five registers are basic control, basic status, advertisement, link-partner ability and expansion.

Whenever negotiation is enabled and a restart condition occurs, the block steps through a fixed emulated sequence, one clock per step. First it flags completion. Next it flags a received page. Last it resolves a speed, duplex and pause result and latches it. The result comes from the common abilities of the advertisement and link-partner registers. When the two registers share no ability, configuration inputs supply the speed and duplex instead. Restart conditions are hardware reset, software reset (a control bit, a per-PHY input or a digital-reset input), a reload pulse, and a write of the restart bit.

Top module: `anemu_ctrl`

## Requirements
- R1: After reset, control reads 0x3100 (bit 13 speed, bit 12 enable, bit 8 duplex), advertisement reads 0x01E1, link-partner reads 0x05E1, and the results read 0 while `an_busy` is high.
- R2: A restart condition makes `an_busy` high at the next clock edge while enable is set. Restart conditions are control bit 9 written 1, control bit 15 written 1, a pulse on `soft_rst_in`, `dig_rst_in` or `reload_in`, and enable written from 0 to 1.
- R3: After the start edge, the next edge sets status bit 5 (complete), the edge after that sets expansion bit 1 (page received), and the third edge latches the result and drops `an_busy`.
- R4: The result takes the highest set bit of the AND of ability bits 8..5 of registers 4 and 5. Bit 8 gives 100 Mb/s full, bit 7 gives 100 Mb/s half, bit 6 gives 10 Mb/s full and bit 5 gives 10 Mb/s half.
- R5: If no ability bit is common, the latched speed and duplex are `pd_spd100` and `pd_fdx`.
- R6: The latched pause is the AND of bit 10 of the advertisement and link-partner registers.
- R7: While `an_busy` is low, the latched result does not change, including after advertisement writes.
- R8: With enable (control bit 12) clear, no sequence runs: `an_busy` stays low, status bit 5 reads 0 and the result is held.
- R9: Control bits 15 and 9 are self-clearing and always read 0.
- R10: A read strobe on register 6 clears page received at the next edge, unless the sequence sets it in the same cycle.
- R11: A software reset from control bit 15, `soft_rst_in` or `dig_rst_in` returns control, advertisement and link-partner to their reset values. A reload pulse does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read strobe (clear-on-read side effects) |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| soft_rst_in | input | 1 | Per-PHY software reset pulse |
| dig_rst_in | input | 1 | Digital reset pulse |
| reload_in | input | 1 | Configuration reload pulse |
| pd_spd100 | input | 1 | Parallel-detect speed (1 = 100 Mb/s) |
| pd_fdx | input | 1 | Parallel-detect duplex (1 = full) |
| an_busy | output | 1 | Emulated sequence in progress |
| res_spd100 | output | 1 | Latched speed (1 = 100 Mb/s) |
| res_fdx | output | 1 | Latched duplex (1 = full) |
| res_pause | output | 1 | Latched pause |

## Verification
The hardest situation to reach is the step boundary inside the three-cycle sequence, where the old result must still be visible after completion and page received are already set. The bench first loads a link-partner value that resolves differently from the current result. It then samples status, expansion and result at every negedge after the restart write, so each step is seen in its own cycle. Holding with negotiation disabled is also reached on purpose: the bench clears enable and then fires a reload. The reload would otherwise start a sequence.

// File: rtl/anemu_pkg.sv
package anemu_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_CMPL,
      SQ_PAGE,
      SQ_RES
   } sq_state_e;

   typedef struct packed {
      logic spd100;
      logic fdx;
      logic pause;
   } an_res_t;

   localparam int ABIL_N = 4;
endpackage

// File: rtl/anemu_hcd.sv
module anemu_hcd
   import anemu_pkg::*;
#(
   parameter int ABIL_W = ABIL_N
) (
   input  logic [ABIL_W-1:0] adv_abil,
   input  logic [ABIL_W-1:0] lp_abil,
   input  logic              adv_pause,
   input  logic              lp_pause,
   input  logic              pd_spd100,
   input  logic              pd_fdx,
   output an_res_t           res
);
   localparam int PICK_W = $clog2(ABIL_W);

   if (ABIL_W != 4) begin : g_bad_abil
      $error("anemu_hcd: ABIL_W must be 4");
   end

   logic [ABIL_W-1:0] common;
   logic [PICK_W-1:0] pick;
   logic              found;

   assign common = adv_abil & lp_abil;

   // highest common bit wins; index bit 1 = speed, index bit 0 = duplex
   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int i = ABIL_W - 1; i >= 0; i--) begin
         if (common[i] && !found) begin
            found = 1'b1;
            pick  = PICK_W'(i);
         end
      end
   end

   always_comb begin
      res.pause = adv_pause & lp_pause;
      if (found) begin
         res.spd100 = pick[1];
         res.fdx    = pick[0];
      end else begin
         res.spd100 = pd_spd100;
         res.fdx    = pd_fdx;
      end
   end
endmodule

// File: rtl/anemu_seq.sv
module anemu_seq
   import anemu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic en_next,
   input  logic rd_clr_page,
   output logic busy,
   output logic an_cmpl,
   output logic page_rcvd,
   output logic load_res
);
   sq_state_e state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_CMPL;
         an_cmpl   <= 1'b0;
         page_rcvd <= 1'b0;
      end else if (start) begin
         an_cmpl   <= 1'b0;
         page_rcvd <= 1'b0;
         state     <= en_next ? SQ_CMPL : SQ_IDLE;
      end else begin
         if (rd_clr_page) page_rcvd <= 1'b0;
         if (!en_next) begin
            state   <= SQ_IDLE;
            an_cmpl <= 1'b0;
         end else begin
            case (state)
               SQ_CMPL: begin
                  an_cmpl <= 1'b1;
                  state   <= SQ_PAGE;
               end
               SQ_PAGE: begin
                  page_rcvd <= 1'b1;
                  state     <= SQ_RES;
               end
               SQ_RES:  state <= SQ_IDLE;
               default: state <= SQ_IDLE;
            endcase
         end
      end
   end

   assign busy     = (state != SQ_IDLE);
   assign load_res = (state == SQ_RES) && !start && en_next;

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start && en_next |=> busy);

   p_cmpl_before_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(page_rcvd) |-> an_cmpl);

   p_load_after_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load_res |-> an_cmpl && page_rcvd);

   p_page_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr_page && !start && state != SQ_PAGE |=> !page_rcvd);
endmodule

// File: rtl/anemu_ctrl.sv
module anemu_ctrl
   import anemu_pkg::*;
#(
   parameter int          ADDR_W        = 5,
   parameter int          DATA_W        = 16,
   parameter int          CTRL_A        = 0,
   parameter int          STAT_A        = 1,
   parameter int          ADV_A         = 4,
   parameter int          LP_A          = 5,
   parameter int          EXP_A         = 6,
   parameter logic [3:0]  ADV_ABIL_RST  = 4'hF,
   parameter logic        ADV_PAUSE_RST = 1'b0,
   parameter logic [3:0]  LP_ABIL_RST   = 4'hF,
   parameter logic        LP_PAUSE_RST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_rd,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              soft_rst_in,
   input  logic              dig_rst_in,
   input  logic              reload_in,
   input  logic              pd_spd100,
   input  logic              pd_fdx,
   output logic              an_busy,
   output logic              res_spd100,
   output logic              res_fdx,
   output logic              res_pause
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_A);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_A);
   localparam logic [ADDR_W-1:0] A_ADV  = ADDR_W'(ADV_A);
   localparam logic [ADDR_W-1:0] A_LP   = ADDR_W'(LP_A);
   localparam logic [ADDR_W-1:0] A_EXP  = ADDR_W'(EXP_A);
   localparam logic [4:0]        SELECTOR = 5'b00001;

   if (DATA_W != 16) begin : g_bad_data
      $error("anemu_ctrl: DATA_W must be 16");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("anemu_ctrl: ADDR_W must be at least 3");
   end

   logic        ctl_en, ctl_spd, ctl_dup;
   logic [3:0]  adv_abil, lp_abil;
   logic        adv_pause, lp_pause;
   logic        wr_ctrl, wr_adv, wr_lp;
   logic        soft_evt, start, en_next, rd_clr_page;
   logic        seq_cmpl, seq_page, load_res;
   an_res_t     hcd_res, res_q;

   assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
   assign wr_adv  = reg_wr && (reg_addr == A_ADV);
   assign wr_lp   = reg_wr && (reg_addr == A_LP);
   assign rd_clr_page = reg_rd && (reg_addr == A_EXP);

   assign soft_evt = soft_rst_in | dig_rst_in | (wr_ctrl & reg_wdata[15]);
   assign en_next  = soft_evt ? 1'b1 : (wr_ctrl ? reg_wdata[12] : ctl_en);
   assign start    = soft_evt | reload_in
                   | (wr_ctrl & (reg_wdata[9] | (reg_wdata[12] & ~ctl_en)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en    <= 1'b1;
         ctl_spd   <= 1'b1;
         ctl_dup   <= 1'b1;
         adv_abil  <= ADV_ABIL_RST;
         adv_pause <= ADV_PAUSE_RST;
         lp_abil   <= LP_ABIL_RST;
         lp_pause  <= LP_PAUSE_RST;
      end else if (soft_evt) begin
         ctl_en    <= 1'b1;
         ctl_spd   <= 1'b1;
         ctl_dup   <= 1'b1;
         adv_abil  <= ADV_ABIL_RST;
         adv_pause <= ADV_PAUSE_RST;
         lp_abil   <= LP_ABIL_RST;
         lp_pause  <= LP_PAUSE_RST;
      end else begin
         if (wr_ctrl) begin
            ctl_en  <= reg_wdata[12];
            ctl_spd <= reg_wdata[13];
            ctl_dup <= reg_wdata[8];
         end
         if (wr_adv) begin
            adv_abil  <= reg_wdata[8:5];
            adv_pause <= reg_wdata[10];
         end
         if (wr_lp) begin
            lp_abil  <= reg_wdata[8:5];
            lp_pause <= reg_wdata[10];
         end
      end
   end

   anemu_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .en_next     (en_next),
      .rd_clr_page (rd_clr_page),
      .busy        (an_busy),
      .an_cmpl     (seq_cmpl),
      .page_rcvd   (seq_page),
      .load_res    (load_res)
   );

   anemu_hcd #(.ABIL_W(ABIL_N)) u_hcd (
      .adv_abil  (adv_abil),
      .lp_abil   (lp_abil),
      .adv_pause (adv_pause),
      .lp_pause  (lp_pause),
      .pd_spd100 (pd_spd100),
      .pd_fdx    (pd_fdx),
      .res       (hcd_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        res_q <= '0;
      else if (load_res) res_q <= hcd_res;
   end

   assign res_spd100 = res_q.spd100;
   assign res_fdx    = res_q.fdx;
   assign res_pause  = res_q.pause;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: reg_rdata = {2'b00, ctl_spd, ctl_en, 3'b000, ctl_dup, 8'h00};
         A_STAT: reg_rdata = {10'h000, seq_cmpl, 1'b0, 1'b1, 3'b000};
         A_ADV:  reg_rdata = {5'h00, adv_pause, 1'b0, adv_abil, SELECTOR};
         A_LP:   reg_rdata = {5'h00, lp_pause, 1'b0, lp_abil, SELECTOR};
         A_EXP:  reg_rdata = {14'h0000, seq_page, 1'b0};
         default: reg_rdata = '0;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^{reg_wdata[14], reg_wdata[11:9], reg_wdata[7:0],
                           reg_wdata[15:11]};

   p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !an_busy |=> $stable(res_q));

   p_idle_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |-> !an_busy && !seq_cmpl);

   p_selfclr_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl && !soft_evt |=> ctl_en == $past(reg_wdata[12]));
endmodule

// File: tb/anemu_ctrl_tb.sv
module anemu_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic        reg_rd = 1'b0;
   logic [15:0] reg_rdata;
   logic        soft_rst_in = 1'b0, dig_rst_in = 1'b0, reload_in = 1'b0;
   logic        pd_spd100 = 1'b1, pd_fdx = 1'b1;
   logic        an_busy, res_spd100, res_fdx, res_pause;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   anemu_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .soft_rst_in(soft_rst_in), .dig_rst_in(dig_rst_in), .reload_in(reload_in),
      .pd_spd100(pd_spd100), .pd_fdx(pd_fdx), .an_busy(an_busy),
      .res_spd100(res_spd100), .res_fdx(res_fdx), .res_pause(res_pause)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic peek(input logic [4:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic chk_reg(input string req, input logic [4:0] a, input logic [15:0] exp);
      logic [15:0] d;
      peek(a, d);
      chk(req, d, exp);
   endtask

   task automatic chk_res(input string req, input logic [2:0] exp);
      chk(req, {13'b0, res_spd100, res_fdx, res_pause}, {13'b0, exp});
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic negotiate(input logic [15:0] adv, input logic [15:0] lp);
      wr(5'd4, adv);
      wr(5'd5, lp);
      wr(5'd0, 16'h3300);
      settle();
   endtask

   task automatic t_reset();
      chk_reg("R1 ctrl", 5'd0, 16'h3100);
      chk_reg("R1 adv", 5'd4, 16'h01E1);
      chk_reg("R1 lp", 5'd5, 16'h05E1);
      chk("R1 busy", {15'b0, an_busy}, 16'h1);
      chk_res("R1 res", 3'b000);
      @(negedge clk);
      rst_n = 1'b1;
      settle();
      chk_res("R4 after reset 100FD", 3'b110);
      chk_reg("R3 status complete", 5'd1, 16'h0028);
   endtask

   task automatic t_order();
      wr(5'd5, 16'h0061);
      wr(5'd0, 16'h3300);
      chk("R2 busy after restart", {15'b0, an_busy}, 16'h1);
      chk_reg("R3 step0 status", 5'd1, 16'h0008);
      chk_reg("R9 ctrl self-clear", 5'd0, 16'h3100);
      @(negedge clk);
      chk_reg("R3 step1 status", 5'd1, 16'h0028);
      chk_reg("R3 step1 exp", 5'd6, 16'h0000);
      @(negedge clk);
      chk_reg("R3 step2 exp", 5'd6, 16'h0002);
      chk_res("R3 step2 result old", 3'b110);
      chk("R3 step2 busy", {15'b0, an_busy}, 16'h1);
      @(negedge clk);
      chk("R3 step3 busy", {15'b0, an_busy}, 16'h0);
      chk_res("R3 step3 result 10FD", 3'b010);
   endtask

   task automatic t_hcd();
      pd_spd100 = 1'b1; pd_fdx = 1'b1;
      negotiate(16'h01E1, 16'h00A1); chk_res("R4 100HD", 3'b100);
      negotiate(16'h0061, 16'h01E1); chk_res("R4 10FD", 3'b010);
      negotiate(16'h0021, 16'h01E1); chk_res("R4 10HD", 3'b000);
      negotiate(16'h0141, 16'h01C1); chk_res("R4 100FD", 3'b110);
   endtask

   task automatic t_pd();
      pd_spd100 = 1'b1; pd_fdx = 1'b0;
      negotiate(16'h0181, 16'h0061); chk_res("R5 pd 100 half", 3'b100);
      pd_spd100 = 1'b0; pd_fdx = 1'b1;
      negotiate(16'h0181, 16'h0061); chk_res("R5 pd 10 full", 3'b010);
   endtask

   task automatic t_pause();
      negotiate(16'h05E1, 16'h05E1); chk_res("R6 pause both", 3'b111);
      negotiate(16'h05E1, 16'h01E1); chk_res("R6 pause one", 3'b110);
   endtask

   task automatic t_hold();
      negotiate(16'h05E1, 16'h05E1);
      wr(5'd4, 16'h0021);
      settle();
      chk("R7 no busy after adv write", {15'b0, an_busy}, 16'h0);
      chk_res("R7 result held", 3'b111);
      wr(5'd0, 16'h3300);
      settle();
      chk_res("R7 rerun uses new adv", 3'b000);
   endtask

   task automatic t_sources();
      wr(5'd4, 16'h0021);
      soft_rst_in = 1'b1; @(negedge clk); soft_rst_in = 1'b0;
      chk("R2 soft_rst_in busy", {15'b0, an_busy}, 16'h1);
      chk_reg("R11 soft_rst_in adv", 5'd4, 16'h01E1);
      settle();
      wr(5'd5, 16'h0021);
      dig_rst_in = 1'b1; @(negedge clk); dig_rst_in = 1'b0;
      chk("R2 dig_rst_in busy", {15'b0, an_busy}, 16'h1);
      chk_reg("R11 dig_rst_in lp", 5'd5, 16'h05E1);
      settle();
      wr(5'd4, 16'h0021);
      reload_in = 1'b1; @(negedge clk); reload_in = 1'b0;
      chk("R2 reload busy", {15'b0, an_busy}, 16'h1);
      chk_reg("R11 reload keeps adv", 5'd4, 16'h0021);
      settle();
      chk_res("R2 reload result 10HD", 3'b000);
   endtask

   task automatic t_disable();
      wr(5'd0, 16'h2100);
      chk("R8 busy off", {15'b0, an_busy}, 16'h0);
      chk_reg("R8 status no complete", 5'd1, 16'h0008);
      wr(5'd4, 16'h01E1);
      reload_in = 1'b1; @(negedge clk); reload_in = 1'b0;
      chk("R8 reload ignored", {15'b0, an_busy}, 16'h0);
      settle();
      chk_res("R8 result held", 3'b000);
      chk_reg("R8 status still clear", 5'd1, 16'h0008);
      wr(5'd0, 16'h3100);
      chk("R2 enable rise restarts", {15'b0, an_busy}, 16'h1);
      settle();
      chk_res("R8 reenabled result", 3'b110);
   endtask

   task automatic t_page();
      chk_reg("R10 page set", 5'd6, 16'h0002);
      chk_reg("R10 plain peek keeps", 5'd6, 16'h0002);
      reg_addr = 5'd6; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      chk_reg("R10 cleared by read", 5'd6, 16'h0000);
      chk_reg("R10 complete kept", 5'd1, 16'h0028);
   endtask

   task automatic t_softbit();
      wr(5'd4, 16'h0021);
      wr(5'd5, 16'h0021);
      wr(5'd0, 16'h8000);
      chk_reg("R11 ctrl default", 5'd0, 16'h3100);
      chk_reg("R11 adv default", 5'd4, 16'h01E1);
      chk_reg("R11 lp default", 5'd5, 16'h05E1);
      chk("R2 bit15 busy", {15'b0, an_busy}, 16'h1);
      settle();
      chk_res("R11 result after soft reset", 3'b110);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_order();
      t_hcd();
      t_pd();
      t_pause();
      t_hold();
      t_sources();
      t_disable();
      t_page();
      t_softbit();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule